// File: doc/BRIEF.md
# Execute-Stage ALU with Operand Control

This block is the arithmetic unit in the execute stage of a small 32-bit load/store processor. It receives two register operands, the 16-bit immediate field of the current instruction, the 6-bit major opcode and the 6-bit function field. It also receives two controls from the hardwired decoder. One picks how the immediate is widened. The other picks whether operand B is the second register or the widened immediate. A third control, the operation source, says where the ALU operation comes from:

- the function field, for register-register instructions;
- the opcode, for register-immediate instructions;
- a forced add, used by loads and stores to form base plus displacement;
- a zero test, used by conditional branches on the first operand.

The unit is purely combinational. It produces a 32-bit result and a zero flag in the same cycle its inputs are presented. Fetch, the register file, data memory and next-PC selection sit outside it.

Top module: `exu_alu_unit`

## Requirements
- R1: With `ext_mode` = 0 (sign), the widened immediate carries `imm_field` in bits 15:0 and copies bit 15 into bits 31:16.
- R2: With `ext_mode` = 1 (zero), the widened immediate carries `imm_field` in bits 15:0 and zeros in bits 31:16.
- R3: With `ext_mode` = 2 (high), the widened immediate carries `imm_field` in bits 31:16 and zeros in bits 15:0. With `ext_mode` = 3, the widened immediate is zero.
- R4: When `b_from_imm` is 0, operand B is `opnd_b`. When it is 1, operand B is the widened immediate and `opnd_b` has no effect on `result`.
- R5: With `op_src` = 0, the operation comes from `func_code` and `opcode` is ignored. The codes are: 0x01 add, 0x02 subtract (A−B), 0x04 AND, 0x05 OR, 0x06 XOR, 0x07 NOT (~A), 0x0A less-than, 0x0B greater-than, 0x0C equal.
- R6: With `op_src` = 1, the operation comes from `opcode` and `func_code` is ignored. The codes are: 0x08 add, 0x09 subtract, 0x0C AND, 0x0D OR, 0x0E XOR, 0x0F NOT (~A), 0x0A less-than, 0x0B greater-than, 0x04 equal.
- R7: With `op_src` = 2, the result is A + B, whatever `opcode` and `func_code` hold.
- R8: With `op_src` = 3 (zero test), the result is `opnd_a` unchanged. `zero` is therefore high exactly when `opnd_a` is zero, whatever operand B and the codes hold.
- R9: Less-than and greater-than compare A and B as signed two's-complement values. All three comparisons give 32'd1 when true and 32'd0 when false.
- R10: Any function or opcode value not listed in R5/R6 gives a result of 0.
- R11: `zero` is high exactly when `result` is all zeros.
- R12: Add and subtract wrap modulo 2^32 with no flag or saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First register operand (rs) |
| opnd_b | input | 32 | Second register operand (rt) |
| imm_field | input | 16 | Immediate field of the instruction |
| opcode | input | 6 | Major opcode, bits 31:26 of the instruction |
| func_code | input | 6 | Function field, bits 5:0 of the instruction |
| ext_mode | input | 2 | Immediate widening: 0 sign, 1 zero, 2 high half, 3 none |
| b_from_imm | input | 1 | Operand B select: 0 register, 1 widened immediate |
| op_src | input | 2 | Operation source: 0 function field, 1 opcode, 2 forced add, 3 zero test |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so a wrong value anywhere inside shows on `result` and `zero` in the same cycle the inputs are applied. A faulty extender shows up on immediates with bit 15 set, where the sign and zero modes must differ. A faulty decoder shows up when the two code spaces are crossed: a code is valid as a function but undefined as an opcode, or a code names one operation in the function space and another in the opcode space (0x0C and 0x04 are swapped). A wrong comparison shows up on operands of opposite sign, where signed and unsigned order disagree.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int CODE_W = 6;

    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_HIGH = 2'd2,
        EXT_NONE = 2'd3
    } ext_mode_e;

    typedef enum logic [1:0] {
        SRC_FUNC  = 2'd0,
        SRC_OPC   = 2'd1,
        SRC_ADD   = 2'd2,
        SRC_ZTEST = 2'd3
    } op_src_e;

    typedef enum logic [3:0] {
        ALU_NONE  = 4'd0,
        ALU_ADD   = 4'd1,
        ALU_SUB   = 4'd2,
        ALU_AND   = 4'd3,
        ALU_OR    = 4'd4,
        ALU_XOR   = 4'd5,
        ALU_NOT   = 4'd6,
        ALU_LT    = 4'd7,
        ALU_GT    = 4'd8,
        ALU_EQ    = 4'd9,
        ALU_PASSA = 4'd10
    } alu_op_e;

    // function-field codes (register-register forms)
    localparam logic [CODE_W-1:0] FN_ADD = 6'h01;
    localparam logic [CODE_W-1:0] FN_SUB = 6'h02;
    localparam logic [CODE_W-1:0] FN_AND = 6'h04;
    localparam logic [CODE_W-1:0] FN_OR  = 6'h05;
    localparam logic [CODE_W-1:0] FN_XOR = 6'h06;
    localparam logic [CODE_W-1:0] FN_NOT = 6'h07;
    localparam logic [CODE_W-1:0] FN_LT  = 6'h0A;
    localparam logic [CODE_W-1:0] FN_GT  = 6'h0B;
    localparam logic [CODE_W-1:0] FN_EQ  = 6'h0C;

    // opcode codes (register-immediate forms)
    localparam logic [CODE_W-1:0] OP_ADDI = 6'h08;
    localparam logic [CODE_W-1:0] OP_SUBI = 6'h09;
    localparam logic [CODE_W-1:0] OP_ANDI = 6'h0C;
    localparam logic [CODE_W-1:0] OP_ORI  = 6'h0D;
    localparam logic [CODE_W-1:0] OP_XORI = 6'h0E;
    localparam logic [CODE_W-1:0] OP_NOTI = 6'h0F;
    localparam logic [CODE_W-1:0] OP_LTI  = 6'h0A;
    localparam logic [CODE_W-1:0] OP_GTI  = 6'h0B;
    localparam logic [CODE_W-1:0] OP_EQI  = 6'h04;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } operands_t;

    function automatic logic is_compare(input alu_op_e op);
        return (op == ALU_LT) || (op == ALU_GT) || (op == ALU_EQ);
    endfunction

    function automatic logic [DATA_W-1:0] bool_word(input logic v);
        return {{(DATA_W-1){1'b0}}, v};
    endfunction

endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext
    import exu_pkg::*;
#(
    parameter int IN_W  = IMM_W,
    parameter int OUT_W = DATA_W
) (
    input  logic [IN_W-1:0]  imm_in,
    input  ext_mode_e        mode,
    output logic [OUT_W-1:0] imm_out
);
    localparam int PAD_W = OUT_W - IN_W;

    logic [PAD_W-1:0] sign_pad;
    assign sign_pad = {PAD_W{imm_in[IN_W-1]}};

    always_comb begin
        unique case (mode)
            EXT_SIGN: imm_out = {sign_pad, imm_in};
            EXT_ZERO: imm_out = {{PAD_W{1'b0}}, imm_in};
            EXT_HIGH: imm_out = {imm_in, {(OUT_W-IN_W){1'b0}}};
            default:  imm_out = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({mode, imm_in})) begin
            if (mode == EXT_SIGN)
                assert_sign_upper_uniform_R1: assert (
                    ($countones(imm_out[OUT_W-1:IN_W]) == 0) ||
                    ($countones(imm_out[OUT_W-1:IN_W]) == PAD_W));
            if (mode == EXT_ZERO)
                assert_zero_upper_clear_R2: assert (imm_out[OUT_W-1:IN_W] == '0);
            if (mode == EXT_HIGH)
                assert_high_lower_clear_R3: assert (imm_out[OUT_W-IN_W-1:0] == '0);
        end
    end
endmodule

// File: rtl/exu_op_decode.sv
module exu_op_decode
    import exu_pkg::*;
(
    input  logic [CODE_W-1:0] func_code,
    input  logic [CODE_W-1:0] opcode,
    input  op_src_e           src,
    output alu_op_e           alu_op
);
    alu_op_e fn_op;
    alu_op_e oc_op;

    always_comb begin
        case (func_code)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_XOR:  fn_op = ALU_XOR;
            FN_NOT:  fn_op = ALU_NOT;
            FN_LT:   fn_op = ALU_LT;
            FN_GT:   fn_op = ALU_GT;
            FN_EQ:   fn_op = ALU_EQ;
            default: fn_op = ALU_NONE;
        endcase
    end

    always_comb begin
        case (opcode)
            OP_ADDI: oc_op = ALU_ADD;
            OP_SUBI: oc_op = ALU_SUB;
            OP_ANDI: oc_op = ALU_AND;
            OP_ORI:  oc_op = ALU_OR;
            OP_XORI: oc_op = ALU_XOR;
            OP_NOTI: oc_op = ALU_NOT;
            OP_LTI:  oc_op = ALU_LT;
            OP_GTI:  oc_op = ALU_GT;
            OP_EQI:  oc_op = ALU_EQ;
            default: oc_op = ALU_NONE;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_FUNC:  alu_op = fn_op;
            SRC_OPC:   alu_op = oc_op;
            SRC_ADD:   alu_op = ALU_ADD;
            default:   alu_op = ALU_PASSA;
        endcase
    end
endmodule

// File: rtl/exu_alu_core.sv
module exu_alu_core
    import exu_pkg::*;
#(
    parameter int  W          = DATA_W,
    parameter bit  SIGNED_CMP = 1'b1
) (
    input  operands_t    ops,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         zero
);
    logic lt_flag;
    logic gt_flag;
    logic eq_flag;

    generate
        if (SIGNED_CMP) begin : g_signed_cmp
            assign lt_flag = $signed(ops.a) < $signed(ops.b);
            assign gt_flag = $signed(ops.a) > $signed(ops.b);
        end else begin : g_unsigned_cmp
            assign lt_flag = ops.a < ops.b;
            assign gt_flag = ops.a > ops.b;
        end
    endgenerate

    assign eq_flag = (ops.a == ops.b);

    always_comb begin
        case (op)
            ALU_ADD:   res = ops.a + ops.b;
            ALU_SUB:   res = ops.a - ops.b;
            ALU_AND:   res = ops.a & ops.b;
            ALU_OR:    res = ops.a | ops.b;
            ALU_XOR:   res = ops.a ^ ops.b;
            ALU_NOT:   res = ~ops.a;
            ALU_LT:    res = bool_word(lt_flag);
            ALU_GT:    res = bool_word(gt_flag);
            ALU_EQ:    res = bool_word(eq_flag);
            ALU_PASSA: res = ops.a;
            default:   res = '0;
        endcase
    end

    assign zero = ~|res;

    always_comb begin
        if (!$isunknown({ops, op})) begin
            if (is_compare(op))
                assert_cmp_is_bool_R9: assert (res[W-1:1] == '0);
            if (op == ALU_NONE)
                assert_none_gives_zero_R10: assert (res == '0);
            if (op == ALU_PASSA)
                assert_ztest_follows_a_R8: assert (zero == (ops.a == '0));
        end
    end
endmodule

// File: rtl/exu_alu_unit.sv
module exu_alu_unit
    import exu_pkg::*;
(
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [15:0] imm_field,
    input  logic [5:0]  opcode,
    input  logic [5:0]  func_code,
    input  logic [1:0]  ext_mode,
    input  logic        b_from_imm,
    input  logic [1:0]  op_src,
    output logic [31:0] result,
    output logic        zero
);
    logic [DATA_W-1:0] imm_wide;
    alu_op_e           op_sel;
    operands_t         ops;

    exu_imm_ext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_ext (
        .imm_in  (imm_field),
        .mode    (ext_mode_e'(ext_mode)),
        .imm_out (imm_wide)
    );

    exu_op_decode u_dec (
        .func_code (func_code),
        .opcode    (opcode),
        .src       (op_src_e'(op_src)),
        .alu_op    (op_sel)
    );

    always_comb begin
        ops.a = opnd_a;
        ops.b = b_from_imm ? imm_wide : opnd_b;
    end

    exu_alu_core #(.W(DATA_W), .SIGNED_CMP(1'b1)) u_core (
        .ops  (ops),
        .op   (op_sel),
        .res  (result),
        .zero (zero)
    );

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, imm_field, opcode, func_code,
                         ext_mode, b_from_imm, op_src})) begin
            assert_zero_matches_result_R11: assert (zero == (result == '0));
            if (b_from_imm)
                assert_bsel_imm_R4: assert (ops.b == imm_wide);
            if (op_src == 2'd2)
                assert_forced_add_R7: assert (op_sel == ALU_ADD);
            if (op_src == 2'd3)
                assert_ztest_pass_R8: assert (result == opnd_a);
        end
    end
endmodule

// File: tb/test_exu_alu_unit.sv
module test_exu_alu_unit;
    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] imm_field = '0;
    logic [5:0]  opcode = '0, func_code = '0;
    logic [1:0]  ext_mode = '0, op_src = '0;
    logic        b_from_imm = 1'b0;
    logic [31:0] result;
    logic        zero;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exu_alu_unit i_exu_alu_unit (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_field(imm_field),
        .opcode(opcode), .func_code(func_code), .ext_mode(ext_mode),
        .b_from_imm(b_from_imm), .op_src(op_src),
        .result(result), .zero(zero)
    );

    function automatic logic [31:0] ref_ext(input logic [15:0] im, input logic [1:0] m);
        case (m)
            2'd0: return {{16{im[15]}}, im};
            2'd1: return {16'h0, im};
            2'd2: return {im, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    // kind: 0 none,1 add,2 sub,3 and,4 or,5 xor,6 not,7 lt,8 gt,9 eq
    function automatic int fn_kind(input logic [5:0] c);
        case (c)
            6'h01: return 1; 6'h02: return 2; 6'h04: return 3;
            6'h05: return 4; 6'h06: return 5; 6'h07: return 6;
            6'h0A: return 7; 6'h0B: return 8; 6'h0C: return 9;
            default: return 0;
        endcase
    endfunction

    function automatic int oc_kind(input logic [5:0] c);
        case (c)
            6'h08: return 1; 6'h09: return 2; 6'h0C: return 3;
            6'h0D: return 4; 6'h0E: return 5; 6'h0F: return 6;
            6'h0A: return 7; 6'h0B: return 8; 6'h04: return 9;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] ref_result();
        logic [31:0] b;
        int k;
        b = b_from_imm ? ref_ext(imm_field, ext_mode) : opnd_b;
        case (op_src)
            2'd0: k = fn_kind(func_code);
            2'd1: k = oc_kind(opcode);
            2'd2: k = 1;
            default: return opnd_a;
        endcase
        case (k)
            1: return opnd_a + b;
            2: return opnd_a - b;
            3: return opnd_a & b;
            4: return opnd_a | b;
            5: return opnd_a ^ b;
            6: return ~opnd_a;
            7: return ($signed(opnd_a) < $signed(b)) ? 32'd1 : 32'd0;
            8: return ($signed(opnd_a) > $signed(b)) ? 32'd1 : 32'd0;
            9: return (opnd_a == b) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                         input logic [5:0] oc, input logic [5:0] fn, input logic [1:0] em,
                         input logic bi, input logic [1:0] src);
        @(posedge clk);
        opnd_a = a; opnd_b = b; imm_field = im; opcode = oc; func_code = fn;
        ext_mode = em; b_from_imm = bi; op_src = src;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] exp_res);
        checks++;
        if (result !== exp_res || zero !== (exp_res == 32'h0)) begin
            errors++;
            $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                     req, result, zero, exp_res, exp_res == 32'h0);
        end
    endtask

    initial begin
        int seed;
        logic [5:0] fn_pool [12];
        logic [5:0] oc_pool [12];
        fn_pool = '{6'h01, 6'h02, 6'h04, 6'h05, 6'h06, 6'h07, 6'h0A, 6'h0B, 6'h0C, 6'h08, 6'h00, 6'h3F};
        oc_pool = '{6'h08, 6'h09, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h0A, 6'h0B, 6'h04, 6'h01, 6'h00, 6'h3F};
        seed = $urandom(32'd1234);

        // R11 initial state: all-zero inputs, function code 0 undefined
        @(negedge clk);
        check("R11 idle", 32'h0);

        // R1 / R2 / R3 extension with bit 15 set, forced add with A=0
        apply(32'h0, 32'hDEAD_BEEF, 16'h8001, 6'h00, 6'h00, 2'd0, 1'b1, 2'd2);
        check("R1 sign ext", 32'hFFFF_8001);
        apply(32'h0, 32'hDEAD_BEEF, 16'h8001, 6'h00, 6'h00, 2'd1, 1'b1, 2'd2);
        check("R2 zero ext", 32'h0000_8001);
        apply(32'h0, 32'hDEAD_BEEF, 16'h8001, 6'h00, 6'h00, 2'd2, 1'b1, 2'd2);
        check("R3 high place", 32'h8001_0000);
        apply(32'h5, 32'hDEAD_BEEF, 16'h8001, 6'h00, 6'h00, 2'd3, 1'b1, 2'd2);
        check("R3 mode3 none", 32'h5);
        // R4 register B vs immediate B
        apply(32'h10, 32'h20, 16'h0003, 6'h00, 6'h01, 2'd0, 1'b0, 2'd0);
        check("R4 reg B", 32'h30);
        apply(32'h10, 32'h20, 16'h0003, 6'h00, 6'h01, 2'd0, 1'b1, 2'd0);
        check("R4 imm B", 32'h13);
        // R5 / R6 crossed codes: 0x0C is EQ as function, AND as opcode
        apply(32'hF0F0, 32'hF0F0, 16'h0, 6'h04, 6'h0C, 2'd0, 1'b0, 2'd0);
        check("R5 fn eq", 32'h1);
        apply(32'hF0F0, 32'h0FF0, 16'h0FF0, 6'h0C, 6'h0C, 2'd1, 1'b1, 2'd1);
        check("R6 op and", 32'h00F0);
        // R7 forced add ignores codes; R12 wraps
        apply(32'hFFFF_FFFF, 32'h0, 16'h0002, 6'h09, 6'h02, 2'd0, 1'b1, 2'd2);
        check("R7 R12 add wrap", 32'h1);
        apply(32'h0, 32'h1, 16'h0, 6'h00, 6'h02, 2'd0, 1'b0, 2'd0);
        check("R12 sub wrap", 32'hFFFF_FFFF);
        // R8 zero test
        apply(32'h0, 32'h7, 16'h1234, 6'h08, 6'h01, 2'd0, 1'b1, 2'd3);
        check("R8 ztest zero", 32'h0);
        apply(32'h8000_0000, 32'h0, 16'h0, 6'h08, 6'h01, 2'd0, 1'b0, 2'd3);
        check("R8 ztest nonzero", 32'h8000_0000);
        // R9 signed compare, opposite signs
        apply(32'hFFFF_FFFF, 32'h1, 16'h0, 6'h00, 6'h0A, 2'd0, 1'b0, 2'd0);
        check("R9 lt signed", 32'h1);
        apply(32'hFFFF_FFFF, 32'h1, 16'h0, 6'h00, 6'h0B, 2'd0, 1'b0, 2'd0);
        check("R9 gt signed", 32'h0);
        apply(32'h5, 32'h0, 16'hFFFF, 6'h0B, 6'h00, 2'd0, 1'b1, 2'd1);
        check("R9 gti sign imm", 32'h1);
        // R10 undefined codes
        apply(32'h5, 32'h6, 16'h0, 6'h01, 6'h08, 2'd0, 1'b0, 2'd0);
        check("R10 fn undefined", 32'h0);
        apply(32'h5, 32'h6, 16'h0, 6'h01, 6'h08, 2'd0, 1'b0, 2'd1);
        check("R10 op undefined", 32'h0);

        // random mix: covers R1..R12
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom;
            rb = ($urandom_range(0, 7) == 0) ? ra : $urandom;
            if ($urandom_range(0, 9) == 0) ra = 32'h0;
            apply(ra, rb, 16'($urandom), oc_pool[$urandom_range(0, 11)],
                  fn_pool[$urandom_range(0, 11)], 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
            check("R5 R6 R11 random", ref_result());
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule